// File: doc/BRIEF.md
# Instruction Line Fetch with Error-Tagged Fill

This block fetches instruction lines for a processor core. On a core fetch request it issues one line-aligned read on a simple request/acknowledge bus. It then gathers the eight returned 32-bit words into a fill buffer, in ascending word order. Every returned word comes with an error flag, which the buffer keeps per word next to a valid bit.

A line whose beats all arrived clean, and which was marked cacheable, is offered to the cache through a one-cycle commit strobe. A line that carried any error is still kept in the fill buffer, so its words can be executed, but it is never committed. The execute stage reads words out of the buffer by index. Reading a valid word that arrived with an error raises a machine-check pulse one cycle later. Errored words that are never read raise nothing.

After reset the block issues no request until the bus busy input has been seen low at least once. This keeps a core-only reset from disturbing bus traffic that is still in flight. Once that has happened, the busy input no longer affects fetching.

Top module: `ifetch_fill`

## Requirements
- R1: After reset, bus_req stays low, even with fetch_req held high, until bus_busy has been sampled low on at least one clock edge. After that, bus_busy has no effect on fetching.
- R2: An accepted fetch drives bus_req high with bus_addr equal to fetch_addr with its low 5 bits cleared. Both hold steady until the cycle in which bus_ack is high.
- R3: Read-data beats are accepted only after the request has been acknowledged. Beat k (k = 0..7) fills word k, and beats may arrive in consecutive cycles or with idle gaps between them.
- R4: bus_err is counted only in a cycle where bus_rdack is high. An error pulse in any other cycle has no effect on commit or machine check.
- R5: One cycle after the eighth beat, line_commit is high for exactly one cycle if the line was cacheable and no beat had an error. line_data then holds word k at bits [32k+31:32k], and line_addr holds the line address.
- R6: A line with any errored beat produces no line_commit, yet all its words remain readable through exec_word with exec_valid high.
- R7: A line fetched with fetch_cacheable low never produces line_commit.
- R8: mcheck goes high for one cycle, in the cycle after exec_rd selects a valid word that arrived with an error. Reading clean words, or leaving errored words unread, never raises mcheck.
- R9: exec_valid is low for words not yet received in the current line, and after reset. Reading such a word raises no mcheck.
- R10: A fetch_req presented while a line fill is in progress is ignored. No further bus request appears after that fill completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Core requests a line fetch |
| fetch_addr | input | 32 | Byte address of the wanted instruction |
| fetch_cacheable | input | 1 | Line may be written to the cache |
| bus_busy | input | 1 | Bus reports outstanding activity |
| bus_req | output | 1 | Read request to the bus |
| bus_addr | output | 32 | Line-aligned read address |
| bus_ack | input | 1 | Bus accepts the request |
| bus_rdack | input | 1 | Read-data beat valid |
| bus_rdata | input | 32 | Read-data word |
| bus_err | input | 1 | Error flag for the current beat |
| line_commit | output | 1 | One-cycle strobe: clean line ready for the cache |
| line_addr | output | 32 | Address of the buffered line |
| line_data | output | 256 | Buffered line, word k at bits [32k+31:32k] |
| exec_rd | input | 1 | Execute stage consumes a word |
| exec_idx | input | 3 | Word index within the line |
| exec_valid | output | 1 | Selected word has been received |
| exec_word | output | 32 | Selected word |
| mcheck | output | 1 | Machine-check pulse for an executed errored word |

## Verification
The hardest case to reach is a machine check that depends on which word is executed, rather than on whether the line had an error. To reach it, the stimulus fills a line with one errored beat and then reads that word and its clean neighbours one at a time. It also fills a line whose only error is on the final beat and never reads that word. A second subtle case is an error pulse outside a data beat. The bus model places such pulses in the acknowledge cycle and in idle gaps between beats, and the line must still commit. A fetch request raised in the middle of a fill, and a word read before its beat has arrived, are driven between beats of a live transfer.

// File: rtl/ifetch_fill.sv
module ifetch_fill #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WORDS = 8,
  localparam int IW = $clog2(WORDS),
  localparam int OFS = $clog2(WORDS * DW / 8)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_req,
  input  logic [AW-1:0]       fetch_addr,
  input  logic                fetch_cacheable,
  input  logic                bus_busy,
  output logic                bus_req,
  output logic [AW-1:0]       bus_addr,
  input  logic                bus_ack,
  input  logic                bus_rdack,
  input  logic [DW-1:0]       bus_rdata,
  input  logic                bus_err,
  output logic                line_commit,
  output logic [AW-1:0]       line_addr,
  output logic [WORDS*DW-1:0] line_data,
  input  logic                exec_rd,
  input  logic [IW-1:0]       exec_idx,
  output logic                exec_valid,
  output logic [DW-1:0]       exec_word,
  output logic                mcheck
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA} state_t;

  state_t           state_q;
  logic             unlocked_q;
  logic [AW-1:0]    addr_q;
  logic             cach_q;
  logic [IW-1:0]    beat_q;
  logic [DW-1:0]    buf_q [WORDS];
  logic [WORDS-1:0] vld_q;
  logic [WORDS-1:0] err_q;
  logic             commit_q;
  logic             mchk_q;

  wire go   = (state_q == S_IDLE) && fetch_req && unlocked_q;
  wire take = (state_q == S_DATA) && bus_rdack;
  wire last = take && (beat_q == IW'(WORDS - 1));

  assign bus_req     = (state_q == S_REQ);
  assign bus_addr    = addr_q;
  assign line_addr   = addr_q;
  assign line_commit = commit_q;
  assign exec_valid  = vld_q[exec_idx];
  assign exec_word   = buf_q[exec_idx];
  assign mcheck      = mchk_q;

  for (genvar k = 0; k < WORDS; k++) begin : g_line
    assign line_data[k*DW +: DW] = buf_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      unlocked_q <= 1'b0;
      addr_q     <= '0;
      cach_q     <= 1'b0;
      beat_q     <= '0;
      vld_q      <= '0;
      err_q      <= '0;
      commit_q   <= 1'b0;
      mchk_q     <= 1'b0;
    end else begin
      if (!bus_busy) unlocked_q <= 1'b1;
      commit_q <= last && cach_q && !(|err_q) && !bus_err;
      mchk_q   <= exec_rd && vld_q[exec_idx] && err_q[exec_idx];
      case (state_q)
        S_IDLE: if (go) begin
          state_q <= S_REQ;
          addr_q  <= {fetch_addr[AW-1:OFS], {OFS{1'b0}}};
          cach_q  <= fetch_cacheable;
          vld_q   <= '0;
          err_q   <= '0;
          beat_q  <= '0;
        end
        S_REQ: if (bus_ack) state_q <= S_DATA;
        default: if (take) begin
          vld_q[beat_q] <= 1'b1;
          err_q[beat_q] <= bus_err;
          beat_q        <= beat_q + 1'b1;
          if (last) state_q <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) buf_q[beat_q] <= bus_rdata;
  end

  AST_REQ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q |-> !bus_req); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr)); // R2
  AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    line_commit |-> (&vld_q) && !(|err_q)); // R5
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    line_commit |=> !line_commit); // R5
  AST_MCHK_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    mcheck |-> $past(exec_rd)); // R8

endmodule

// File: tb/ifetch_fill_tb_top.sv
`timescale 1ns/1ps
module ifetch_fill_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic fetch_req = 0, fetch_cacheable = 0, bus_busy = 1;
  logic [31:0] fetch_addr = 0, bus_rdata = 0;
  logic bus_ack = 0, bus_rdack = 0, bus_err = 0;
  logic bus_req, line_commit, exec_valid, mcheck, exec_rd = 0;
  logic [31:0] bus_addr, line_addr, exec_word;
  logic [255:0] line_data;
  logic [2:0] exec_idx = 0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ifetch_fill dut_i (.clk, .rst_n, .fetch_req, .fetch_addr, .fetch_cacheable, .bus_busy,
    .bus_req, .bus_addr, .bus_ack, .bus_rdack, .bus_rdata, .bus_err, .line_commit,
    .line_addr, .line_data, .exec_rd, .exec_idx, .exec_valid, .exec_word, .mcheck);

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(input logic [7:0] tag, input int i);
    return 32'hC0DE0000 | (32'(tag) << 8) | 32'(i);
  endfunction

  task automatic start_fetch(input logic [31:0] a, input bit c);
    fetch_req = 1; fetch_addr = a; fetch_cacheable = c;
    for (int n = 0; n < 20 && !bus_req; n++) @(negedge clk);
    fetch_req = 0;
    chk(bus_req, "R2 req raised", 64'(bus_req), 1);
    chk(bus_addr == (a & 32'hFFFF_FFE0), "R2 aligned addr", 64'(bus_addr), 64'(a & 32'hFFFF_FFE0));
  endtask

  task automatic grant(input bit stray);
    bus_ack = 1; bus_err = stray;
    @(negedge clk);
    bus_ack = 0; bus_err = 0;
  endtask

  task automatic beat(input logic [31:0] d, input bit e);
    bus_rdack = 1; bus_rdata = d; bus_err = e;
    @(negedge clk);
    bus_rdack = 0; bus_err = 0;
  endtask

  task automatic exec_chk(input int idx, input bit ev, input logic [31:0] ew, input bit em, input string r);
    exec_rd = 1; exec_idx = 3'(idx);
    #1;
    chk(exec_valid == ev, {r, " exec_valid"}, 64'(exec_valid), 64'(ev));
    if (ev) chk(exec_word == ew, {r, " exec_word"}, 64'(exec_word), 64'(ew));
    @(negedge clk);
    exec_rd = 0;
    #1;
    chk(mcheck == em, {r, " mcheck"}, 64'(mcheck), 64'(em));
    @(negedge clk);
    chk(!mcheck, {r, " mcheck pulse"}, 64'(mcheck), 0);
  endtask

  task automatic t_reset;
    chk(!bus_req, "R1 reset req", 64'(bus_req), 0);
    chk(!line_commit, "R5 reset commit", 64'(line_commit), 0);
    chk(!mcheck, "R8 reset mcheck", 64'(mcheck), 0);
    chk(!exec_valid, "R9 reset valid", 64'(exec_valid), 0);
  endtask

  task automatic t_lock_and_clean;
    fetch_req = 1; fetch_addr = 32'h1234_5678; fetch_cacheable = 1;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      chk(!bus_req, "R1 held off while busy", 64'(bus_req), 0);
    end
    bus_busy = 0;
    @(negedge clk);
    bus_busy = 1;
    start_fetch(32'h1234_5678, 1);
    for (int n = 0; n < 2; n++) begin
      @(negedge clk);
      chk(bus_req && bus_addr == 32'h1234_5660, "R2 hold until ack", 64'(bus_addr), 64'h1234_5660);
    end
    grant(0);
    for (int i = 0; i < 8; i++) beat(wd(8'h11, i), 0);
    chk(line_commit, "R5 commit clean", 64'(line_commit), 1);
    chk(line_addr == 32'h1234_5660, "R5 line_addr", 64'(line_addr), 64'h1234_5660);
    for (int i = 0; i < 8; i++)
      chk(line_data[32*i +: 32] == wd(8'h11, i), "R5 R3 line word", 64'(line_data[32*i +: 32]), 64'(wd(8'h11, i)));
    @(negedge clk);
    chk(!line_commit, "R5 single pulse", 64'(line_commit), 0);
    exec_chk(4, 1, wd(8'h11, 4), 0, "R8 clean word");
  endtask

  task automatic t_err_line;
    start_fetch(32'h0000_2004, 1);
    grant(1);
    for (int i = 0; i < 8; i++) beat(wd(8'h22, i), i == 3);
    chk(!line_commit, "R6 no commit on error", 64'(line_commit), 0);
    @(negedge clk);
    chk(!line_commit, "R6 no late commit", 64'(line_commit), 0);
    exec_chk(2, 1, wd(8'h22, 2), 0, "R8 clean neighbour");
    exec_chk(3, 1, wd(8'h22, 3), 1, "R8 R6 errored word executed");
    exec_chk(4, 1, wd(8'h22, 4), 0, "R8 clean after error");
  endtask

  task automatic t_stray_err;
    start_fetch(32'h0000_3000, 1);
    grant(1);
    for (int i = 0; i < 8; i++) begin
      beat(wd(8'h33, i), 0);
      if (i < 7) begin
        bus_err = 1;
        @(negedge clk);
        bus_err = 0;
      end
    end
    chk(line_commit, "R4 R3 stray error ignored, gaps", 64'(line_commit), 1);
    chk(line_data[32*7 +: 32] == wd(8'h33, 7), "R3 gapped last word", 64'(line_data[32*7 +: 32]), 64'(wd(8'h33, 7)));
    @(negedge clk);
    exec_chk(5, 1, wd(8'h33, 5), 0, "R4 no mcheck from stray");
  endtask

  task automatic t_noncache;
    start_fetch(32'h0000_4010, 0);
    grant(0);
    for (int i = 0; i < 8; i++) beat(wd(8'h44, i), 0);
    chk(!line_commit, "R7 uncacheable no commit", 64'(line_commit), 0);
    @(negedge clk);
    exec_chk(7, 1, wd(8'h44, 7), 0, "R7 uncacheable readable");
  endtask

  task automatic t_partial;
    start_fetch(32'h0000_5000, 1);
    grant(0);
    for (int i = 0; i < 3; i++) beat(wd(8'h55, i), 0);
    exec_chk(5, 0, 0, 0, "R9 word not yet received");
    fetch_req = 1; fetch_addr = 32'h0000_9000;
    @(negedge clk);
    fetch_req = 0;
    for (int i = 3; i < 8; i++) beat(wd(8'h55, i), i == 7);
    chk(!line_commit, "R6 last beat error", 64'(line_commit), 0);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk(!bus_req, "R10 mid-fill request ignored", 64'(bus_req), 0);
    end
    for (int i = 0; i < 7; i++) exec_chk(i, 1, wd(8'h55, i), 0, "R8 unexecuted error silent");
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lock_and_clean();
    t_err_line();
    t_stray_err();
    t_noncache();
    t_partial();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule